// File: doc/BRIEF.md
# Delayed Write Transaction Queue

This block sits between the initiator-side and target-side halves of a bus bridge and handles the writes that cannot be posted: I/O writes and type-1 configuration writes. When such a write appears for the first time, the block claims it and answers with a retry. It records the write in a small in-order queue. The entry at the head of that queue is replayed on the target side whenever the posted-write path reports that ordering allows it. A target retry makes the block try again. After a bounded number of failed attempts the entry is discarded and a sticky error is raised.

When the target accepts the head entry, the completion is held. It is handed back only when the initiator repeats the identical transaction: the same command, address, byte enables and data. That repeat is answered with a ready, plus a stop if the initiator wants more than one DWORD, and the entry is then released. Each delayed write carries a single DWORD. The initiator-side response is combinational on the request strobe, and all queue state changes on the following clock edge.

Top module: `delayed_write_queue`

## Requirements
- R1: Only command 4'b0011 (I/O write), and command 4'b1011 (configuration write) with address bits [1:0] = 2'b01 (type 1), are delayed. Any other request gets no claim, retry or ready, and is never queued.
- R2: A delayed request that does not complete a held entry is answered in the same cycle with claim and retry. If it is accepted, its command, address, address parity, data, byte enables and data parity are stored.
- R3: A delayed request is refused (claim and retry, nothing stored) when a held entry has the same command and address, or when all DEPTH entries are in use. A refusal for a full queue does not prevent acceptance later, once space is free.
- R4: The target request is raised only for the head entry, only while ordering_ok_i is high, and it carries exactly the stored fields, parities included.
- R5: A target retry leaves the head entry in place, and the same write is presented again.
- R6: When the head entry has received 2^LOG_SHORT target retries (2^LOG_LONG when long_limit_i is high), it is removed from the queue and err_o is set. err_o stays set until err_clr_i is pulsed.
- R7: serr_o is high exactly when err_o and serr_en_i are both high.
- R8: After the target accepts the head entry, no further target request is made for it. A repeat with identical command, address, byte enables and data gets claim and ready without retry, and the entry is removed.
- R9: stop_o is raised together with ready when the completing initiator asserts req_multi_i, and not otherwise.
- R10: A repeat whose data differs, or whose entry is not yet completed, is answered with retry only.
- R11: Entries are issued on the target side in the order they were accepted.
- R12: After reset the queue is empty, no target request is made, and err_o and serr_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Initiator request present this cycle |
| req_cmd_i | input | 4 | Bus command |
| req_addr_i | input | 32 | Address |
| req_addr_par_i | input | 1 | Address parity |
| req_data_i | input | 32 | First data DWORD |
| req_be_i | input | 4 | Byte enables |
| req_data_par_i | input | 1 | Data parity |
| req_multi_i | input | 1 | Initiator asks for more than one DWORD |
| claim_o | output | 1 | Access claimed |
| retry_o | output | 1 | Target retry to initiator |
| trdy_o | output | 1 | Completion returned |
| stop_o | output | 1 | Disconnect together with ready |
| ordering_ok_i | input | 1 | Posted data ordering satisfied |
| long_limit_i | input | 1 | Select the long retry limit |
| tgt_req_o | output | 1 | Target-side write request |
| tgt_cmd_o | output | 4 | Replayed command |
| tgt_addr_o | output | 32 | Replayed address |
| tgt_addr_par_o | output | 1 | Replayed address parity |
| tgt_data_o | output | 32 | Replayed data |
| tgt_be_o | output | 4 | Replayed byte enables |
| tgt_data_par_o | output | 1 | Replayed data parity |
| tgt_done_i | input | 1 | Target accepted the write |
| tgt_retry_i | input | 1 | Target retried the write |
| serr_en_i | input | 1 | System error enable |
| err_clr_i | input | 1 | Clear the sticky error |
| err_o | output | 1 | Sticky retry-limit error |
| serr_o | output | 1 | System error |

## Verification
The assertions check on every cycle the properties that hold at a single cycle: a non-delayed command is never claimed, a claim carries exactly one of retry or ready, stop only appears with ready, the target request is gated by ordering, the head is held after a target retry, no request follows a target acceptance, and the error is sticky and gated. The bench scenarios cover the behaviour that depends on history and can only be shown over time. These are duplicate and full-queue refusal, first-in first-out replay of the exact captured fields, completion only on an identical repeat at the head, and the exact retry count (short and long) at which an entry is dropped.

// File: rtl/dwq_pkg.sv
package dwq_pkg;
  localparam int unsigned CMD_W  = 4;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;

  localparam logic [CMD_W-1:0] CMD_IO_WR  = 4'b0011;
  localparam logic [CMD_W-1:0] CMD_CFG_WR = 4'b1011;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic              addr_par;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
    logic              data_par;
  } dwq_entry_t;

  function automatic logic is_delayed(logic [CMD_W-1:0] cmd, logic [ADDR_W-1:0] addr);
    return (cmd == CMD_IO_WR) || ((cmd == CMD_CFG_WR) && (addr[1:0] == 2'b01));
  endfunction
endpackage

// File: rtl/dwq_store.sv
module dwq_store
  import dwq_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  dwq_entry_t        push_entry_i,
  input  logic              pop_i,
  input  logic [CMD_W-1:0]  look_cmd_i,
  input  logic [ADDR_W-1:0] look_addr_i,
  output dwq_entry_t        head_o,
  output logic              head_valid_o,
  output logic              full_o,
  output logic              dup_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  dwq_entry_t       slot_q [DEPTH];
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] hit;
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign hit[i] = vld_q[i] && (slot_q[i].cmd == look_cmd_i) && (slot_q[i].addr == look_addr_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i]  <= 1'b0;
        slot_q[i] <= '0;
      end else begin
        if (push_i && (wr_ptr_q == PTR_W'(i))) begin
          vld_q[i]  <= 1'b1;
          slot_q[i] <= push_entry_i;
        end else if (pop_i && (rd_ptr_q == PTR_W'(i))) begin
          vld_q[i] <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      if (push_i) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (pop_i)  rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    end
  end

  assign head_o       = slot_q[rd_ptr_q];
  assign head_valid_o = vld_q[rd_ptr_q];
  assign full_o       = &vld_q;
  assign dup_o        = |hit;
endmodule

// File: rtl/dwq_replay.sv
module dwq_replay #(
  parameter int unsigned LOG_SHORT = 24,
  parameter int unsigned LOG_LONG  = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic head_valid_i,
  input  logic cpl_pop_i,
  input  logic ordering_ok_i,
  input  logic long_limit_i,
  input  logic tgt_done_i,
  input  logic tgt_retry_i,
  input  logic err_clr_i,
  output logic tgt_req_o,
  output logic head_done_o,
  output logic drop_o,
  output logic err_o
);
  localparam int unsigned CNT_W = LOG_LONG;
  localparam logic [CNT_W-1:0] LIM_SHORT = CNT_W'((64'd1 << LOG_SHORT) - 64'd1);
  localparam logic [CNT_W-1:0] LIM_LONG  = CNT_W'((64'd1 << LOG_LONG) - 64'd1);

  logic [CNT_W-1:0] cnt_q, lim;
  logic             done_q, err_q, at_lim;

  assign lim       = long_limit_i ? LIM_LONG : LIM_SHORT;
  assign at_lim    = (cnt_q == lim);
  assign tgt_req_o = head_valid_i && !done_q && ordering_ok_i;
  // done has priority over a simultaneous retry
  assign drop_o    = tgt_req_o && tgt_retry_i && !tgt_done_i && at_lim;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (cpl_pop_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (tgt_req_o && tgt_done_i) begin
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else if (tgt_req_o && tgt_retry_i) begin
      cnt_q <= at_lim ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (drop_o)    err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end

  assign head_done_o = done_q;
  assign err_o       = err_q;
endmodule

// File: rtl/delayed_write_queue.sv
module delayed_write_queue
  import dwq_pkg::*;
#(
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned LOG_SHORT = 24,
  parameter int unsigned LOG_LONG  = 32
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  input  logic [3:0]  req_cmd_i,
  input  logic [31:0] req_addr_i,
  input  logic        req_addr_par_i,
  input  logic [31:0] req_data_i,
  input  logic [3:0]  req_be_i,
  input  logic        req_data_par_i,
  input  logic        req_multi_i,
  output logic        claim_o,
  output logic        retry_o,
  output logic        trdy_o,
  output logic        stop_o,
  input  logic        ordering_ok_i,
  input  logic        long_limit_i,
  output logic        tgt_req_o,
  output logic [3:0]  tgt_cmd_o,
  output logic [31:0] tgt_addr_o,
  output logic        tgt_addr_par_o,
  output logic [31:0] tgt_data_o,
  output logic [3:0]  tgt_be_o,
  output logic        tgt_data_par_o,
  input  logic        tgt_done_i,
  input  logic        tgt_retry_i,
  input  logic        serr_en_i,
  input  logic        err_clr_i,
  output logic        err_o,
  output logic        serr_o
);
  dwq_entry_t head, new_entry;
  logic head_valid, head_done, full, dup, drop;
  logic dly, cpl_hit, push, pop;

  assign new_entry = '{cmd: req_cmd_i, addr: req_addr_i, addr_par: req_addr_par_i,
                       data: req_data_i, be: req_be_i, data_par: req_data_par_i};

  assign dly     = req_valid_i && is_delayed(req_cmd_i, req_addr_i);
  assign cpl_hit = dly && head_valid && head_done &&
                   (head.cmd == req_cmd_i) && (head.addr == req_addr_i) &&
                   (head.be == req_be_i) && (head.data == req_data_i);

  assign claim_o = dly;
  assign trdy_o  = cpl_hit;
  assign stop_o  = cpl_hit && req_multi_i;
  assign retry_o = dly && !cpl_hit;
  assign push    = dly && !cpl_hit && !dup && !full;
  assign pop     = cpl_hit || drop;

  dwq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .push_i       (push),
    .push_entry_i (new_entry),
    .pop_i        (pop),
    .look_cmd_i   (req_cmd_i),
    .look_addr_i  (req_addr_i),
    .head_o       (head),
    .head_valid_o (head_valid),
    .full_o       (full),
    .dup_o        (dup)
  );

  dwq_replay #(.LOG_SHORT(LOG_SHORT), .LOG_LONG(LOG_LONG)) u_replay (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .head_valid_i  (head_valid),
    .cpl_pop_i     (cpl_hit),
    .ordering_ok_i (ordering_ok_i),
    .long_limit_i  (long_limit_i),
    .tgt_done_i    (tgt_done_i),
    .tgt_retry_i   (tgt_retry_i),
    .err_clr_i     (err_clr_i),
    .tgt_req_o     (tgt_req_o),
    .head_done_o   (head_done),
    .drop_o        (drop),
    .err_o         (err_o)
  );

  assign tgt_cmd_o      = head.cmd;
  assign tgt_addr_o     = head.addr;
  assign tgt_addr_par_o = head.addr_par;
  assign tgt_data_o     = head.data;
  assign tgt_be_o       = head.be;
  assign tgt_data_par_o = head.data_par;
  assign serr_o         = err_o && serr_en_i;
endmodule

// File: rtl/delayed_write_queue_chk.sv
module delayed_write_queue_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic [3:0]  req_cmd_i,
  input logic [31:0] req_addr_i,
  input logic        claim_o,
  input logic        retry_o,
  input logic        trdy_o,
  input logic        stop_o,
  input logic        ordering_ok_i,
  input logic        tgt_req_o,
  input logic [3:0]  tgt_cmd_o,
  input logic [31:0] tgt_addr_o,
  input logic [31:0] tgt_data_o,
  input logic        tgt_done_i,
  input logic        tgt_retry_i,
  input logic        serr_en_i,
  input logic        err_clr_i,
  input logic        err_o,
  input logic        serr_o
);
  logic non_dly;
  assign non_dly = req_valid_i && !((req_cmd_i == 4'b0011) ||
                   ((req_cmd_i == 4'b1011) && (req_addr_i[1:0] == 2'b01)));

  AST_NON_DLY_NO_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    non_dly |-> !claim_o && !retry_o && !trdy_o); // R1
  AST_CLAIM_ONE_ANSWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_o |-> (retry_o ^ trdy_o)); // R2
  AST_ANSWER_NEEDS_CLAIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_o || trdy_o) |-> claim_o); // R2
  AST_ISSUE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_req_o |-> ordering_ok_i); // R4
  AST_HOLD_ON_RETRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_req_o && tgt_retry_i && !tgt_done_i && !err_o) |=>
      (err_o || ($stable(tgt_addr_o) && $stable(tgt_cmd_o) && $stable(tgt_data_o)))); // R5
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o); // R6
  AST_SERR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    serr_o |-> (serr_en_i && err_o)); // R7
  AST_NO_ISSUE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_req_o && tgt_done_i) |=> !tgt_req_o); // R8
  AST_STOP_WITH_TRDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> trdy_o); // R9
endmodule

bind delayed_write_queue delayed_write_queue_chk u_chk (.*);

// File: tb/tb_delayed_write_queue.sv
module tb_delayed_write_queue;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int LOG_SHORT = 3;
  localparam int LOG_LONG = 4;
  localparam logic [3:0] IO_WR = 4'b0011, CFG_WR = 4'b1011, MEM_WR = 4'b0111;

  typedef struct packed {
    logic [3:0] cmd; logic [31:0] addr; logic ap; logic [31:0] data; logic [3:0] be; logic dp;
  } item_t;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ap = 0, req_dp = 0, req_multi = 0;
  logic [3:0] req_cmd = 0, req_be = 0;
  logic [31:0] req_addr = 0, req_data = 0;
  logic ordering_ok = 0, long_limit = 0, tgt_done = 0, tgt_retry = 0, serr_en = 0, err_clr = 0;
  logic claim, retry, trdy, stop, tgt_req, tgt_ap, tgt_dp, err, serr;
  logic [3:0] tgt_cmd, tgt_be;
  logic [31:0] tgt_addr, tgt_data;

  int n_chk = 0, n_fail = 0;
  int mon_need = 2, mon_lim = 8, mon_given = 0, mon_last_drop = 0;
  item_t exp_q[$];
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  delayed_write_queue #(.DEPTH(DEPTH), .LOG_SHORT(LOG_SHORT), .LOG_LONG(LOG_LONG)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_cmd_i(req_cmd),
    .req_addr_i(req_addr), .req_addr_par_i(req_ap), .req_data_i(req_data), .req_be_i(req_be),
    .req_data_par_i(req_dp), .req_multi_i(req_multi), .claim_o(claim), .retry_o(retry),
    .trdy_o(trdy), .stop_o(stop), .ordering_ok_i(ordering_ok), .long_limit_i(long_limit),
    .tgt_req_o(tgt_req), .tgt_cmd_o(tgt_cmd), .tgt_addr_o(tgt_addr), .tgt_addr_par_o(tgt_ap),
    .tgt_data_o(tgt_data), .tgt_be_o(tgt_be), .tgt_data_par_o(tgt_dp), .tgt_done_i(tgt_done),
    .tgt_retry_i(tgt_retry), .serr_en_i(serr_en), .err_clr_i(err_clr), .err_o(err), .serr_o(serr));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // driver: one request, checks the same-cycle answer, pushes expected replay
  task automatic send(input logic [3:0] cmd, input logic [31:0] addr, input logic [31:0] data,
                      input logic [3:0] be, input bit multi, input bit e_claim, input bit e_trdy,
                      input bit enq, input string req);
    logic [3:0] ans, e_ans;
    @(negedge clk);
    req_cmd = cmd; req_addr = addr; req_data = data; req_be = be; req_multi = multi;
    req_ap = ^addr; req_dp = ^data; req_valid = 1;
    #1;
    ans   = {claim, retry, trdy, stop};
    e_ans = {e_claim, e_claim & ~e_trdy, e_trdy, e_trdy & multi};
    chk(ans == e_ans, req, "claim/retry/trdy/stop", ans, e_ans);
    if (enq) exp_q.push_back('{cmd, addr, ^addr, data, be, ^data});
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic wait_left(input int n);
    while (exp_q.size() != n) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: target responder and scoreboard for replayed writes (R4, R5, R11)
  initial forever begin
    @(negedge clk); #2;
    if (tgt_req) begin
      if (exp_q.size() == 0) begin
        chk(0, "R4", "unexpected target request", tgt_addr, 0);
        tgt_retry = 1; tgt_done = 0;
      end else begin
        item_t act;
        act = '{tgt_cmd, tgt_addr, tgt_ap, tgt_data, tgt_be, tgt_dp};
        chk(act == exp_q[0], "R11", "replayed entry", act, exp_q[0]);
        if (mon_given >= mon_need) begin
          tgt_done = 1; tgt_retry = 0; mon_given = 0; void'(exp_q.pop_front());
        end else begin
          tgt_done = 0; tgt_retry = 1; mon_given++;
          if (mon_given == mon_lim) begin
            mon_last_drop = mon_given; mon_given = 0; void'(exp_q.pop_front());
          end
        end
      end
    end else begin
      tgt_done = 0; tgt_retry = 0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1; #1;
    chk({tgt_req, err, serr, claim} == 4'b0, "R12", "idle after reset",
        {tgt_req, err, serr, claim}, 0);

    send(MEM_WR, 32'h0000_0100, 32'h1, 4'hF, 0, 0, 0, 0, "R1");
    send(CFG_WR, 32'h0000_0200, 32'h2, 4'hF, 0, 0, 0, 0, "R1");
    send(IO_WR,  32'h0000_1004, 32'hA0A0, 4'h3, 0, 1, 0, 1, "R2");
    send(IO_WR,  32'h0000_1004, 32'hA0A0, 4'h3, 0, 1, 0, 0, "R3");
    send(IO_WR,  32'h0000_1004, 32'hBEEF, 4'h3, 0, 1, 0, 0, "R3");
    send(CFG_WR, 32'h0000_2001, 32'hB1B1, 4'hF, 0, 1, 0, 1, "R2");
    send(IO_WR,  32'h0000_3000, 32'hC2C2, 4'h1, 0, 1, 0, 1, "R2");
    send(IO_WR,  32'h0000_4000, 32'hD3D3, 4'h8, 0, 1, 0, 1, "R2");
    send(IO_WR,  32'h0000_5000, 32'hE4E4, 4'hF, 0, 1, 0, 0, "R3");
    repeat (3) @(negedge clk);
    #1 chk(tgt_req == 0, "R4", "no issue without ordering", tgt_req, 0);

    @(negedge clk); ordering_ok = 1;
    wait_left(3);
    #3 chk(tgt_req == 0, "R8", "no reissue after done", tgt_req, 0);
    send(IO_WR, 32'h0000_1004, 32'h5555, 4'h3, 0, 1, 0, 0, "R10");
    send(IO_WR, 32'h0000_1004, 32'hA0A0, 4'h3, 1, 1, 1, 0, "R8");
    wait_left(2);
    send(CFG_WR, 32'h0000_2001, 32'hB1B1, 4'hF, 0, 1, 1, 0, "R9");
    wait_left(1);
    send(IO_WR, 32'h0000_4000, 32'hD3D3, 4'h8, 0, 1, 0, 0, "R10");
    send(IO_WR, 32'h0000_3000, 32'hC2C2, 4'h1, 1, 1, 1, 0, "R9");
    wait_left(0);
    send(IO_WR, 32'h0000_4000, 32'hD3D3, 4'h8, 0, 1, 1, 0, "R8");
    send(IO_WR, 32'h0000_5000, 32'hE4E4, 4'hF, 0, 1, 0, 1, "R3");
    wait_left(0);
    send(IO_WR, 32'h0000_5000, 32'hE4E4, 4'hF, 0, 1, 1, 0, "R8");
    #3 chk(err == 0, "R5", "no error after normal retries", err, 0);

    mon_need = 1000; mon_lim = 8;
    send(IO_WR, 32'h0000_6000, 32'hF5F5, 4'hF, 0, 1, 0, 1, "R2");
    while (!err) @(negedge clk);
    chk(mon_last_drop == 8, "R6", "short retry limit", mon_last_drop, 8);
    chk(exp_q.size() == 0, "R6", "entry dropped", exp_q.size(), 0);
    repeat (4) @(negedge clk);
    #3 chk(tgt_req == 0, "R6", "no issue after drop", tgt_req, 0);
    chk(err == 1, "R6", "error sticky", err, 1);
    chk(serr == 0, "R7", "serr masked", serr, 0);
    @(negedge clk); serr_en = 1; #1;
    chk(serr == 1, "R7", "serr enabled", serr, 1);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0; #1;
    chk({err, serr} == 2'b00, "R6", "error cleared", {err, serr}, 0);

    @(negedge clk); long_limit = 1; mon_lim = 16;
    send(IO_WR, 32'h0000_7000, 32'h0707, 4'h2, 0, 1, 0, 1, "R2");
    while (!err) @(negedge clk);
    chk(mon_last_drop == 16, "R6", "long retry limit", mon_last_drop, 16);
    #1 chk(serr == 1, "R7", "serr follows error", serr, 1);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0; #1;
    chk(err == 0, "R6", "error cleared again", err, 0);
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule